// File: doc/BRIEF.md
# Register-File ALU Datapath

A 16-bit execution datapath for a small processor core. An eight-entry register file with one write port and one asynchronous read port feeds two operand registers. The left operand can be forced to zero. The right operand passes through a one-bit shifter or is replaced by a short sign-extended immediate. A four-function ALU combines the two operands, and its result and flags are captured in two separately enabled registers. The value written back to the register file comes from a one-hot selector over four sources: memory data, a long sign-extended immediate, the program counter, and the result register itself.

Each control input (write enable, operand loads, result and status loads, selects and opcodes) is driven cycle by cycle by an external sequencer. An operation therefore spans several cycles: the register file is written, then the operands are loaded, then the result is captured. Reset is asynchronous and active-low, and its deassertion is expected to arrive already synchronous to `clk`. Reset clears the operand, result and status registers. The register file has no reset.

Top module: `dp16_core`

## Requirements
- R1: On a rising edge with `wr_en` high, entry `wr_idx` takes the writeback value. With `wr_en` low no entry changes. `rd_idx` reads an entry combinationally, and an entry never written reads as undefined.
- R2: `wb_sel` is one-hot: 4'b0001 selects `result_q`, 4'b0010 selects `pc_val`, 4'b0100 selects `imm8_sx` and 4'b1000 selects `mem_data`.
- R3: The left operand register loads the read-port value when `ld_a` is high. The right operand register loads the same read-port value when `ld_b` is high. Each register otherwise holds its value.
- R4: With `zero_a` high the ALU left input is zero; otherwise it is the left operand register. With `imm_b` high the ALU right input is `imm5_sx`; otherwise it is the shifter output.
- R5: `shift_op` acts on the right operand as follows. 00 passes it unchanged. 01 shifts it left by one with zero fill. 10 shifts it right by one with zero fill. 11 shifts it right by one and copies bit 15 into the vacated bit.
- R6: `alu_op` selects the function: 00 = left + right, 01 = left − right, 10 = left AND right, 11 = NOT right.
- R7: `result_q` loads the ALU result on an edge with `ld_c` high and otherwise holds, whatever the operands or opcode do.
- R8: `status_q` loads on an edge with `ld_s` high and otherwise holds. Bit 0 is set when the result is zero, bit 1 equals result bit 15, and bit 2 is signed overflow for add and subtract and is 0 for AND and NOT.
- R9: While `rst_n` is low, `result_q`, `status_q` and both operand registers read zero.
- R10: A register-file write and an operand load that use the same index on the same edge capture the entry's old contents. A result-feedback writeback (4'b0001) on the edge that also loads `result_q` writes the old result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data | input | 16 | Memory data writeback source |
| imm8_sx | input | 16 | Sign-extended long immediate, writeback source |
| imm5_sx | input | 16 | Sign-extended short immediate, ALU right input |
| pc_val | input | 16 | Program counter writeback source |
| wr_idx | input | 3 | Register-file write index |
| wr_en | input | 1 | Register-file write enable |
| rd_idx | input | 3 | Register-file read index |
| wb_sel | input | 4 | One-hot writeback source select |
| ld_a | input | 1 | Left operand register load |
| ld_b | input | 1 | Right operand register load |
| ld_c | input | 1 | Result register load |
| ld_s | input | 1 | Status register load |
| zero_a | input | 1 | Force ALU left input to zero |
| imm_b | input | 1 | Select short immediate as ALU right input |
| shift_op | input | 2 | Shifter code |
| alu_op | input | 2 | ALU function code |
| status_q | output | 3 | Status flags {overflow, negative, zero} |
| result_q | output | 16 | Result register |

## Verification
Two pairs of functions can coincide on one edge. A register-file write can land while an operand register loads from the same index. A result-feedback writeback can occur while the result register takes a new value. The bench provokes each case with both enables raised in one cycle. It then reads back the operand, through an AND of the operand with itself, and the written entry. Each must show the value from before the edge: the operand holds the old entry, and the feedback entry holds the previous result while `result_q` already shows the new one.

// File: rtl/dp16_pkg.sv
package dp16_pkg;

  typedef enum logic [1:0] {
    SH_PASS = 2'b00,
    SH_LSL  = 2'b01,
    SH_LSR  = 2'b10,
    SH_ASR  = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_AND  = 2'b10,
    OP_NOTB = 2'b11
  } alu_e;

  typedef struct packed {
    logic ovf;
    logic neg;
    logic zero;
  } flags_t;

  localparam int WB_RES  = 0;
  localparam int WB_PC   = 1;
  localparam int WB_IMM8 = 2;
  localparam int WB_MEM  = 3;
  localparam int WB_SRCS = 4;

endpackage

// File: rtl/dp16_regfile.sv
module dp16_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem_q [DEPTH];

  // No reset on the storage array.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];

  // R1: a write lands in the addressed entry
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/dp16_shifter.sv
module dp16_shifter
  import dp16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  always_comb begin
    unique case (shift_e'(op))
      SH_PASS: dout = din;
      SH_LSL:  dout = {din[W-2:0], 1'b0};
      SH_LSR:  dout = {1'b0, din[W-1:1]};
      default: dout = {din[W-1], din[W-1:1]};
    endcase
  end

endmodule

// File: rtl/dp16_alu.sv
module dp16_alu
  import dp16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res,
  output flags_t       flags
);

  logic          is_sub;
  logic [W-1:0]  rhs_adj;
  logic [W-1:0]  sum;
  logic          arith;

  assign is_sub  = (alu_e'(op) == OP_SUB);
  assign rhs_adj = is_sub ? ~rhs : rhs;
  assign sum     = lhs + rhs_adj + {{(W-1){1'b0}}, is_sub};
  assign arith   = (alu_e'(op) == OP_ADD) || is_sub;

  always_comb begin
    unique case (alu_e'(op))
      OP_ADD,
      OP_SUB:  res = sum;
      OP_AND:  res = lhs & rhs;
      default: res = ~rhs;
    endcase
  end

  always_comb begin
    flags.zero = (res == '0);
    flags.neg  = res[W-1];
    flags.ovf  = arith && (lhs[W-1] == rhs_adj[W-1]) && (sum[W-1] != lhs[W-1]);
  end

endmodule

// File: rtl/dp16_core.sv
module dp16_core
  import dp16_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int FW   = $bits(flags_t)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  mem_data,
  input  logic [W-1:0]  imm8_sx,
  input  logic [W-1:0]  imm5_sx,
  input  logic [W-1:0]  pc_val,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] rd_idx,
  input  logic [3:0]    wb_sel,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          ld_c,
  input  logic          ld_s,
  input  logic          zero_a,
  input  logic          imm_b,
  input  logic [1:0]    shift_op,
  input  logic [1:0]    alu_op,
  output logic [FW-1:0] status_q,
  output logic [W-1:0]  result_q
);

  logic [W-1:0] wb_src [WB_SRCS];
  logic [W-1:0] wb_data;
  logic [W-1:0] rd_data;
  logic [W-1:0] a_q, a_d, b_q, b_d, c_d;
  logic [W-1:0] sh_out, lhs, rhs, alu_res;
  flags_t       alu_flags;
  logic [FW-1:0] s_d;

  // Writeback selector: AND-OR over the one-hot code.
  assign wb_src[WB_RES]  = result_q;
  assign wb_src[WB_PC]   = pc_val;
  assign wb_src[WB_IMM8] = imm8_sx;
  assign wb_src[WB_MEM]  = mem_data;

  always_comb begin
    wb_data = '0;
    for (int i = 0; i < WB_SRCS; i++) begin
      wb_data = wb_data | (wb_src[i] & {W{wb_sel[i]}});
    end
  end

  dp16_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wb_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // Operand staging: next state
  always_comb begin
    a_d = ld_a ? rd_data : a_q;
    b_d = ld_b ? rd_data : b_q;
  end

  // Operand staging: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  dp16_shifter #(.W(W)) u_sh (
    .op   (shift_op),
    .din  (b_q),
    .dout (sh_out)
  );

  assign lhs = zero_a ? '0 : a_q;
  assign rhs = imm_b ? imm5_sx : sh_out;

  dp16_alu #(.W(W)) u_alu (
    .op    (alu_op),
    .lhs   (lhs),
    .rhs   (rhs),
    .res   (alu_res),
    .flags (alu_flags)
  );

  // Result and status: next state
  always_comb begin
    c_d = ld_c ? alu_res : result_q;
    s_d = ld_s ? alu_flags : status_q;
  end

  // Result and status: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      status_q <= '0;
    end else begin
      result_q <= c_d;
      status_q <= s_d;
    end
  end

  // R3: an unloaded operand keeps its value
  assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_a |=> $stable(a_q));
  assert_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_b |=> $stable(b_q));

  // R7: the result holds without its enable
  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_c |=> $stable(result_q));

  // R8: status holds without its enable and agrees with a jointly loaded result
  assert_hold_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> $stable(status_q));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_c && ld_s) |=> status_q[0] == (result_q == '0));
  assert_neg_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_c && ld_s) |=> status_q[1] == result_q[W-1]);
  assert_logic_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && alu_op[1]) |=> !status_q[2]);

endmodule

// File: tb/dp16_core_tb.sv
`timescale 1ns/1ps
module dp16_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_data, imm8_sx, imm5_sx, pc_val;
  logic [2:0]  wr_idx, rd_idx;
  logic        wr_en, ld_a, ld_b, ld_c, ld_s, zero_a, imm_b;
  logic [3:0]  wb_sel;
  logic [1:0]  shift_op, alu_op;
  logic [2:0]  status_q;
  logic [15:0] result_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dp16_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .imm8_sx(imm8_sx),
    .imm5_sx(imm5_sx), .pc_val(pc_val), .wr_idx(wr_idx), .wr_en(wr_en),
    .rd_idx(rd_idx), .wb_sel(wb_sel), .ld_a(ld_a), .ld_b(ld_b),
    .ld_c(ld_c), .ld_s(ld_s), .zero_a(zero_a), .imm_b(imm_b),
    .shift_op(shift_op), .alu_op(alu_op), .status_q(status_q),
    .result_q(result_q)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [1:0]  sh;
    logic [1:0]  op;
    logic        za;
    logic        ib;
    logic [15:0] i5;
    logic [15:0] res;
    logic [2:0]  st;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h0003, 16'h0005, 2'b00, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0008, 3'b000},
    '{16'h7FFF, 16'h0001, 2'b00, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h8000, 3'b110},
    '{16'h0005, 16'h0005, 2'b00, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h0000, 3'b001},
    '{16'h8000, 16'h0001, 2'b00, 2'b01, 1'b0, 1'b0, 16'h0000, 16'h7FFF, 3'b100},
    '{16'h00F0, 16'h0F0F, 2'b01, 2'b10, 1'b0, 1'b0, 16'h0000, 16'h0010, 3'b000},
    '{16'h1234, 16'h8002, 2'b10, 2'b11, 1'b0, 1'b0, 16'h0000, 16'hBFFE, 3'b010},
    '{16'h0000, 16'h8002, 2'b11, 2'b11, 1'b0, 1'b0, 16'h0000, 16'h3FFE, 3'b000},
    '{16'h5555, 16'h1111, 2'b00, 2'b00, 1'b1, 1'b1, 16'hFFF0, 16'hFFF0, 3'b010},
    '{16'h5555, 16'h0001, 2'b00, 2'b01, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 3'b010},
    '{16'h8000, 16'h8000, 2'b00, 2'b00, 1'b0, 1'b0, 16'h0000, 16'h0000, 3'b101}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 1'b0; ld_a = 1'b0; ld_b = 1'b0; ld_c = 1'b0; ld_s = 1'b0;
    zero_a = 1'b0; imm_b = 1'b0; shift_op = 2'b00; alu_op = 2'b00;
    wb_sel = 4'b1000;
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] val);
    idle();
    wr_en = 1'b1; wr_idx = idx; wb_sel = 4'b1000; mem_data = val;
    cyc();
    idle();
  endtask

  task automatic ldab(input logic [2:0] ia, input logic [2:0] ib);
    idle();
    rd_idx = ia; ld_a = 1'b1;
    cyc();
    idle();
    rd_idx = ib; ld_b = 1'b1;
    cyc();
    idle();
  endtask

  task automatic exec(input logic [1:0] sh, input logic [1:0] op,
                      input logic za, input logic ib, input logic [15:0] i5);
    idle();
    shift_op = sh; alu_op = op; zero_a = za; imm_b = ib; imm5_sx = i5;
    ld_c = 1'b1; ld_s = 1'b1;
    cyc();
    idle();
  endtask

  // Load both operands from one entry, AND them, leaving the entry in result_q.
  task automatic readout(input logic [2:0] idx);
    idle();
    rd_idx = idx; ld_a = 1'b1; ld_b = 1'b1;
    cyc();
    exec(2'b00, 2'b10, 1'b0, 1'b0, 16'h0000);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mem_data = '0; imm8_sx = '0; imm5_sx = '0; pc_val = '0;
    wr_idx = '0; rd_idx = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 result after reset", result_q, 16'h0000);
    check("R9 status after reset", {13'b0, status_q}, 16'h0000);
    rst_n = 1'b1;
    cyc();

    // Table walk: R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, VECS[i].a);
      wr(3'd2, VECS[i].b);
      ldab(3'd1, 3'd2);
      exec(VECS[i].sh, VECS[i].op, VECS[i].za, VECS[i].ib, VECS[i].i5);
      check($sformatf("R6/R5/R4 vec%0d result", i), result_q, VECS[i].res);
      check($sformatf("R8 vec%0d status", i), {13'b0, status_q}, {13'b0, VECS[i].st});
    end

    // R7 R8: no enables -> both hold
    idle(); alu_op = 2'b00; shift_op = 2'b01;
    cyc();
    check("R7 result hold", result_q, 16'h0000);
    check("R8 status hold", {13'b0, status_q}, 16'h0005);
    // R8: status alone (NOT 0x8000 -> 0x7FFF, flags 000)
    idle(); alu_op = 2'b11; ld_s = 1'b1;
    cyc();
    check("R8 status loads alone", {13'b0, status_q}, 16'h0000);
    check("R7 result unchanged by ld_s", result_q, 16'h0000);
    // R7: result alone (AND -> 0x8000, status stays 000)
    idle(); alu_op = 2'b10; ld_c = 1'b1;
    cyc();
    check("R7 result loads alone", result_q, 16'h8000);
    check("R8 status unchanged by ld_c", {13'b0, status_q}, 16'h0000);
    idle();

    // R1: disabled write leaves the entry alone
    wr(3'd4, 16'hA5A5);
    idle(); wr_idx = 3'd4; wb_sel = 4'b1000; mem_data = 16'h5A5A;
    cyc();
    readout(3'd4);
    check("R1 no write without enable", result_q, 16'hA5A5);

    // R2: writeback sources
    idle(); wr_en = 1'b1; wr_idx = 3'd3; wb_sel = 4'b0010; pc_val = 16'h1357;
    cyc();
    readout(3'd3);
    check("R2 pc source", result_q, 16'h1357);
    idle(); wr_en = 1'b1; wr_idx = 3'd4; wb_sel = 4'b0100; imm8_sx = 16'hFF80;
    cyc();
    readout(3'd4);
    check("R2 imm8 source", result_q, 16'hFF80);
    idle(); wr_en = 1'b1; wr_idx = 3'd5; wb_sel = 4'b0001;
    cyc();
    idle();
    readout(3'd5);
    check("R2 result feedback source", result_q, 16'hFF80);

    // R10: write and operand load on the same index
    wr(3'd6, 16'h1111);
    idle(); wr_en = 1'b1; wr_idx = 3'd6; wb_sel = 4'b1000; mem_data = 16'h2222;
    rd_idx = 3'd6; ld_a = 1'b1; ld_b = 1'b1;
    cyc();
    exec(2'b00, 2'b10, 1'b0, 1'b0, 16'h0000);
    check("R10 operand sees old entry", result_q, 16'h1111);
    readout(3'd6);
    check("R10 entry took new value", result_q, 16'h2222);

    // R10: feedback writeback while the result loads
    wr(3'd1, 16'h0F0F);
    ldab(3'd1, 3'd1);
    idle(); wr_en = 1'b1; wr_idx = 3'd7; wb_sel = 4'b0001;
    alu_op = 2'b00; ld_c = 1'b1; ld_s = 1'b1;
    cyc();
    idle();
    check("R10 new result 0F0F+0F0F", result_q, 16'h1E1E);
    readout(3'd7);
    check("R10 feedback wrote old result", result_q, 16'h2222);

    // R3: left operand holds while the right one reloads
    idle(); rd_idx = 3'd1; ld_a = 1'b1;
    cyc();
    idle(); rd_idx = 3'd6; ld_b = 1'b1;
    cyc();
    exec(2'b00, 2'b10, 1'b0, 1'b0, 16'h0000);
    check("R3 A held, B reloaded", result_q, 16'h0202);

    // R9: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check("R9 async reset result", result_q, 16'h0000);
    check("R9 async reset status", {13'b0, status_q}, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule